// File: doc/BRIEF.md
# Bit-Serial Associative Array Processor

This block holds a small array of word rows, each served by its own one-bit processing element, and a controller that sequences them. Every row works in lockstep on the same bit column. A host sends one command at a time over a valid/ready handshake. With those commands it fills rows, loads a four-bit comparand or a per-row mask, searches every row at once for the comparand in a four-bit window, or merges a bit column into a second flag vector. The per-row flag vectors A and B are always visible on the outputs.

The search runs bit-serially, one bit of the window per cycle. Each row keeps a running match flag, and A is updated only when the last bit has been examined. The OR operation takes one cycle and folds a column of stored bits together with A into B. The mask register decides which rows take part: a row whose mask bit is cleared keeps its A and B bits untouched.

Top module: `assoc_array_proc`

## Requirements
- R1: After reset, tag_a, tag_b and err are zero and cmd_ready is high. Every stored row and the comparand read as zero, and all mask bits are one. A compare at column 0 straight after reset therefore sets every bit of tag_a.
- R2: A command is taken on a rising edge where cmd_valid and cmd_ready are both high. Opcode 2'b00 stores cmd_data into row cmd_row in that cycle, and cmd_ready stays high.
- R3: Opcode 2'b11 with cmd_row[0]=0 loads the comparand from cmd_data[3:0]. With cmd_row[0]=1 it loads the mask from cmd_data[15:0], where mask bit r belongs to row r.
- R4: Opcode 2'b01 with start column c (cmd_col, 0 to 28) marks row r as matching when stored bit c+k equals comparand bit k for every k from 0 to 3. tag_a bit r receives that result.
- R5: After a compare is accepted, cmd_ready is low for exactly four cycles, one per bit. tag_a changes only at the end of that run, and cmd_ready returns high at the same edge.
- R6: A row whose mask bit is 0 keeps its tag_a bit through a compare and its tag_b bit through an OR.
- R7: Opcode 2'b10 with column c (0 to 31) sets tag_b bit r to (stored bit c of row r) OR (tag_a bit r) for each unmasked row, in the cycle of acceptance. cmd_ready does not drop. tag_b changes at no other time.
- R8: A compare whose start column is above 28 is rejected. err goes high, tag_a is unchanged and cmd_ready stays high. The next accepted command of any kind clears err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host presents a command |
| cmd_ready | output | 1 | Block can take a command (low while a compare runs) |
| cmd_op | input | 2 | 00 write row, 01 compare, 10 OR into B, 11 load comparand/mask |
| cmd_row | input | 4 | Row index for writes; bit 0 picks comparand or mask for loads |
| cmd_col | input | 5 | Start column for compare, column for OR |
| cmd_data | input | 32 | Row data, comparand (bits 3:0) or mask (bits 15:0) |
| tag_a | output | 16 | Per-row match flags A |
| tag_b | output | 16 | Per-row result flags B |
| err | output | 1 | Last accepted command was a rejected compare |

## Verification
The properties assume the host obeys the handshake. A command counts only on an edge where ready is high, and no other source drives the flag vectors. Under that assumption, a change of A must coincide with the return of ready, and a change of B must follow an accepted OR. The bench keeps to this by checking cmd_ready on the falling edge before it drives a command and by lowering cmd_valid one cycle later. It also waits for ready to return before it issues the next command, so no command is ever left pending during a compare.

// File: rtl/assoc_array_proc.sv
module assoc_array_proc #(
  parameter int ROWS  = 16,
  parameter int WIDTH = 32,
  parameter int FIELD = 4,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(WIDTH),
  localparam int SW = $clog2(FIELD),
  localparam int LAST_START = WIDTH - FIELD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [RW-1:0]    cmd_row,
  input  logic [CW-1:0]    cmd_col,
  input  logic [WIDTH-1:0] cmd_data,
  output logic [ROWS-1:0]  tag_a,
  output logic [ROWS-1:0]  tag_b,
  output logic             err
);

  localparam logic [1:0] OP_WR  = 2'b00;
  localparam logic [1:0] OP_CMP = 2'b01;
  localparam logic [1:0] OP_OR  = 2'b10;
  localparam logic [1:0] OP_LD  = 2'b11;

  logic [WIDTH-1:0] mem [ROWS];
  logic [FIELD-1:0] cmp_q;
  logic [ROWS-1:0]  mask_q, run_q, a_q, b_q;
  logic [ROWS-1:0]  hit, col_bit;
  logic [CW-1:0]    col_q, bit_idx;
  logic [SW-1:0]    step_q;
  logic             busy_q, err_q;

  wire win_ok = (int'(cmd_col) <= LAST_START);

  assign cmd_ready = ~busy_q;
  assign tag_a     = a_q;
  assign tag_b     = b_q;
  assign err       = err_q;
  assign bit_idx   = col_q + CW'(step_q);

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      hit[r]     = (mem[r][bit_idx] == cmp_q[step_q]);
      col_bit[r] = mem[r][cmd_col];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
      cmp_q  <= '0;
      mask_q <= '1;
      run_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      col_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (busy_q) begin
      run_q  <= run_q & hit;
      step_q <= step_q + 1'b1;
      if (step_q == SW'(FIELD - 1)) begin
        a_q    <= (a_q & ~mask_q) | (run_q & hit & mask_q);
        busy_q <= 1'b0;
      end
    end else if (cmd_valid) begin
      err_q <= 1'b0;
      case (cmd_op)
        OP_WR: mem[cmd_row] <= cmd_data;
        OP_CMP: begin
          if (win_ok) begin
            busy_q <= 1'b1;
            col_q  <= cmd_col;
            step_q <= '0;
            run_q  <= '1;
          end else begin
            err_q <= 1'b1;
          end
        end
        OP_OR: b_q <= (b_q & ~mask_q) | ((col_bit | a_q) & mask_q);
        OP_LD: begin
          if (cmd_row[0]) mask_q <= cmd_data[ROWS-1:0];
          else            cmp_q  <= cmd_data[FIELD-1:0];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/assoc_array_proc_chk.sv
module assoc_array_proc_chk #(
  parameter int ROWS  = 16,
  parameter int WIDTH = 32,
  parameter int FIELD = 4,
  localparam int CW = $clog2(WIDTH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [1:0]      cmd_op,
  input logic [CW-1:0]   cmd_col,
  input logic [ROWS-1:0] tag_a,
  input logic [ROWS-1:0] tag_b,
  input logic [ROWS-1:0] mask,
  input logic            err
);

  wire acc     = cmd_valid && cmd_ready;
  wire cmp_ok  = acc && cmd_op == 2'b01 && int'(cmd_col) <= WIDTH - FIELD;
  wire cmp_bad = acc && cmd_op == 2'b01 && int'(cmd_col) >  WIDTH - FIELD;

  // R5
  cmp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_ok |=> !cmd_ready);

  // R5
  cmp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_ok |-> ##5 cmd_ready);

  // R5
  a_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_a != $past(tag_a)) |-> $rose(cmd_ready));

  // R6
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tag_a ^ $past(tag_a)) & ~mask) == '0);

  // R7
  b_by_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_b != $past(tag_b)) |-> $past(acc && cmd_op == 2'b10));

  // R8
  bad_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_bad |=> (err && cmd_ready && $stable(tag_a)));

endmodule

bind assoc_array_proc assoc_array_proc_chk #(.ROWS(ROWS), .WIDTH(WIDTH), .FIELD(FIELD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_col(cmd_col), .tag_a(tag_a), .tag_b(tag_b),
  .mask(mask_q), .err(err)
);

// File: tb/assoc_array_proc_tb.sv
`timescale 1ns/1ps
module assoc_array_proc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [3:0]  cmd_row = '0;
  logic [4:0]  cmd_col = '0;
  logic [31:0] cmd_data = '0;
  logic [15:0] tag_a, tag_b;
  logic        err;

  int total = 0, bad = 0;
  logic [31:0] sh_mem [16];
  logic [3:0]  sh_cmp;
  logic [15:0] sh_mask, sh_a, sh_b;

  always #2.5 clk = ~clk;

  assoc_array_proc u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_data(cmd_data),
    .tag_a(tag_a), .tag_b(tag_b), .err(err)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [3:0] row, input logic [4:0] col, input logic [31:0] data);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_row = row; cmd_col = col; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic logic [15:0] model_cmp(input int col);
    logic [15:0] res;
    for (int r = 0; r < 16; r++) begin
      res[r] = 1'b1;
      for (int k = 0; k < 4; k++)
        if (sh_mem[r][col + k] != sh_cmp[k]) res[r] = 1'b0;
    end
    return res;
  endfunction

  task automatic do_write(input logic [3:0] row, input logic [31:0] d);
    issue(2'b00, row, 5'd0, d);
    sh_mem[row] = d;
  endtask

  task automatic do_load(input logic sel_mask, input logic [31:0] d);
    issue(2'b11, {3'b0, sel_mask}, 5'd0, d);
    if (sel_mask) sh_mask = d[15:0]; else sh_cmp = d[3:0];
  endtask

  task automatic do_compare(input int col, input string req);
    int n;
    logic [15:0] a_before;
    a_before = tag_a;
    issue(2'b01, 4'd0, 5'(col), 32'd0);
    n = 0;
    while (!cmd_ready && n < 20) begin
      if (n < 4) chk(tag_a == a_before, "R5 A held mid-compare", {16'd0, tag_a}, {16'd0, a_before});
      n++;
      @(negedge clk);
    end
    chk(n == 4, "R5 busy cycles", n, 4);
    sh_a = (sh_a & ~sh_mask) | (model_cmp(col) & sh_mask);
    chk(tag_a == sh_a, req, {16'd0, tag_a}, {16'd0, sh_a});
  endtask

  task automatic do_or(input int col, input string req);
    logic [15:0] colv;
    issue(2'b10, 4'd0, 5'(col), 32'd0);
    for (int r = 0; r < 16; r++) colv[r] = sh_mem[r][col];
    sh_b = (sh_b & ~sh_mask) | ((colv | sh_a) & sh_mask);
    chk(cmd_ready, "R7 ready stays high", {31'd0, cmd_ready}, 1);
    chk(tag_b == sh_b, req, {16'd0, tag_b}, {16'd0, sh_b});
  endtask

  task automatic t_reset;
    chk(tag_a == 0 && tag_b == 0, "R1 flags zero", {tag_a, tag_b}, 0);
    chk(!err && cmd_ready, "R1 err low ready high", {30'd0, err, cmd_ready}, 1);
    for (int r = 0; r < 16; r++) sh_mem[r] = '0;
    sh_cmp = '0; sh_mask = '1; sh_a = '0; sh_b = '0;
    do_compare(0, "R1 zero rows all match");
    chk(tag_a == 16'hFFFF, "R1 mask all ones", {16'd0, tag_a}, 32'hFFFF);
  endtask

  task automatic t_fill;
    for (int r = 0; r < 16; r++) begin
      logic [31:0] d;
      d = (r % 3 == 0) ? 32'h9999_9999 : (32'(r) * 32'h9E37_79B1) ^ {8{4'(r)}};
      do_write(4'(r), d);
      chk(cmd_ready, "R2 write keeps ready", {31'd0, cmd_ready}, 1);
    end
    do_load(1'b0, 32'hFFFF_FFF9);
    do_compare(0, "R2 R3 compare on written rows col0");
  endtask

  task automatic t_columns;
    do_compare(13, "R4 compare col13");
    do_compare(28, "R4 compare last legal col28");
    do_load(1'b0, 32'h6);
    do_compare(5, "R4 compare col5 cmp6");
  endtask

  task automatic t_mask;
    do_load(1'b1, 32'hABCD_0F0F);
    do_load(1'b0, 32'h0);
    do_compare(8, "R6 masked compare keeps A");
    do_or(31, "R6 R7 masked OR col31");
    do_load(1'b1, 32'h0000_FFFF);
    do_or(0, "R7 OR col0");
    do_load(1'b1, 32'h0000_0000);
    do_compare(1, "R6 all masked A unchanged");
  endtask

  task automatic t_bad_window;
    logic [15:0] a_before;
    a_before = tag_a;
    issue(2'b01, 4'd0, 5'd29, 32'd0);
    chk(err == 1'b1, "R8 err on col29", {31'd0, err}, 1);
    chk(cmd_ready, "R8 ready stays high", {31'd0, cmd_ready}, 1);
    chk(tag_a == a_before, "R8 A unchanged", {16'd0, tag_a}, {16'd0, a_before});
    issue(2'b01, 4'd0, 5'd31, 32'd0);
    chk(err == 1'b1, "R8 err on col31", {31'd0, err}, 1);
    do_load(1'b1, 32'h0000_FFFF);
    chk(err == 1'b0, "R8 err cleared", {31'd0, err}, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fill;
    t_columns;
    t_mask;
    t_bad_window;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule